// File: doc/BRIEF.md
# Load/Store Request Credit Tracker

This block sits on the core side of a link to a level-two cache. It decides whether a load request or a store request may be issued in the current cycle. Each kind of request has its own pool of credits. Issuing a request takes one credit from its pool. A pop pulse returned by the cache side gives one credit back. The issue permits `ld_ok` and `st_ok` are high while the matching pool still holds a credit.

The limit for each pool, and the choice of shared mode, are captured into registers during reset. Both pools start full after reset. In shared mode the two pools collapse into a single credit, so at most one request of either kind can be outstanding. A pop that would lift a pool above its limit is not counted. Instead it sets a sticky error flag for that pool, and the flag stays set until the next reset.

Top module: `lsq_credit_gate`

## Requirements
- R1: While `rst` is high, the block captures the load limit, the store limit and the shared-mode bit. After reset both pools hold their full limit and both error flags are 0. A pool whose limit is 0 has its permit low. Changing the configuration inputs outside reset has no effect.
- R2: In separate mode, a load issue while `ld_ok` is high takes one load credit. `ld_ok` goes low once the load pool reaches zero.
- R3: An issue made while its permit is low is ignored, and no credit is taken.
- R4: A pop returns one credit to its pool. An accepted issue and a pop in the same cycle leave the pool count unchanged.
- R5: A pop while the pool already holds its limit, with no accepted issue in that cycle, leaves the count at the limit and sets that pool's error flag. The flag is sticky until reset.
- R6: The store pool behaves like the load pool, with its own count, limit, permit and error flag. Loads and stores in the same cycle do not affect each other.
- R7: In shared mode, both permits are high only while nothing is outstanding. Any accepted issue drops both permits. If a load and a store are issued in the same cycle, the load wins and the store is ignored.
- R8: In shared mode, a load pop or a store pop clears the outstanding request. A pop with nothing outstanding sets the error flag of its own pool. If both pops arrive while a request is outstanding, the load pop clears it and the store pop sets the store error flag.
- R9: A programmed limit above the parameter maximum (8 loads, 32 stores by default) is clamped to that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| cfg_ld_limit | input | LW | Load credit limit |
| cfg_st_limit | input | SW | Store credit limit |
| cfg_shared | input | 1 | 1 = one shared credit for loads and stores |
| ld_issue | input | 1 | Load request issued this cycle |
| st_issue | input | 1 | Store request issued this cycle |
| ld_pop | input | 1 | Load credit returned |
| st_pop | input | 1 | Store credit returned |
| ld_ok | output | 1 | Load may issue |
| st_ok | output | 1 | Store may issue |
| ld_ovf_err | output | 1 | Sticky load overflow error |
| st_ovf_err | output | 1 | Sticky store overflow error |

## Verification
The hardest situation to reach from the ports is a pop that arrives while a pool holds its full limit but is combined with a same-cycle issue or a same-cycle pop of the other kind. These are the cases that decide whether an error is raised or the count is simply held. The stimulus drains each pool to zero, refills it one pop at a time, and pairs issues with pops at the boundaries 0 and 1. It then adds pops beyond the limit. In shared mode it sends both pops together with and without an outstanding request, and it also issues a load and a store in the same cycle. A behavioural model tracks the counts and the outstanding flag, and the bench compares all four outputs against it on every cycle.

// File: rtl/lsq_credit_gate.sv
module lsq_credit_gate #(
  parameter int LD_MAX = 8,
  parameter int ST_MAX = 32,
  localparam int LW = $clog2(LD_MAX + 1),
  localparam int SW = $clog2(ST_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] cfg_ld_limit,
  input  logic [SW-1:0] cfg_st_limit,
  input  logic          cfg_shared,
  input  logic          ld_issue,
  input  logic          st_issue,
  input  logic          ld_pop,
  input  logic          st_pop,
  output logic          ld_ok,
  output logic          st_ok,
  output logic          ld_ovf_err,
  output logic          st_ovf_err
);

  logic [LW-1:0] ld_lim, ld_cnt;
  logic [SW-1:0] st_lim, st_cnt;
  logic shared_q, busy;

  assign ld_ok = shared_q ? !busy : (ld_cnt != '0);
  assign st_ok = shared_q ? !busy : (st_cnt != '0);

  wire ld_go = ld_issue & ld_ok;
  wire st_go = st_issue & st_ok & !(shared_q & ld_go);

  wire ld_ovf = shared_q ? (ld_pop & !busy)
                         : (ld_pop & !ld_go & (ld_cnt == ld_lim));
  wire st_ovf = shared_q ? (st_pop & (!busy | ld_pop))
                         : (st_pop & !st_go & (st_cnt == st_lim));

  wire [LW-1:0] ld_lim_c = (cfg_ld_limit > LW'(LD_MAX)) ? LW'(LD_MAX) : cfg_ld_limit;
  wire [SW-1:0] st_lim_c = (cfg_st_limit > SW'(ST_MAX)) ? SW'(ST_MAX) : cfg_st_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_lim     <= ld_lim_c;
      st_lim     <= st_lim_c;
      ld_cnt     <= ld_lim_c;
      st_cnt     <= st_lim_c;
      shared_q   <= cfg_shared;
      busy       <= 1'b0;
      ld_ovf_err <= 1'b0;
      st_ovf_err <= 1'b0;
    end else begin
      if (ld_ovf) ld_ovf_err <= 1'b1;
      if (st_ovf) st_ovf_err <= 1'b1;
      if (shared_q) begin
        if (ld_go || st_go) busy <= 1'b1;
        else if (ld_pop || st_pop) busy <= 1'b0;
      end else begin
        if (ld_go && !ld_pop) ld_cnt <= ld_cnt - 1'b1;
        else if (ld_pop && !ld_go && !ld_ovf) ld_cnt <= ld_cnt + 1'b1;
        if (st_go && !st_pop) st_cnt <= st_cnt - 1'b1;
        else if (st_pop && !st_go && !st_ovf) st_cnt <= st_cnt + 1'b1;
      end
    end
  end

  assert_ld_within_limit_R5: assert property (@(posedge clk) disable iff (rst)
    ld_cnt <= ld_lim);
  assert_st_within_limit_R6: assert property (@(posedge clk) disable iff (rst)
    st_cnt <= st_lim);
  assert_ld_take_R2: assert property (@(posedge clk) disable iff (rst)
    (!shared_q && ld_issue && ld_ok && !ld_pop) |=> (ld_cnt == $past(ld_cnt) - 1'b1));
  assert_ld_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (ld_issue && !ld_ok && !ld_pop) |=> $stable(ld_cnt));
  assert_issue_pop_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!shared_q && ld_issue && ld_ok && ld_pop) |=> $stable(ld_cnt));
  assert_ld_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ld_ovf_err |=> ld_ovf_err);
  assert_st_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    st_ovf_err |=> st_ovf_err);
  assert_shared_single_R7: assert property (@(posedge clk) disable iff (rst)
    (shared_q && (ld_issue || st_issue) && ld_ok) |=> (!ld_ok && !st_ok));
  assert_shared_return_R8: assert property (@(posedge clk) disable iff (rst)
    (shared_q && !ld_ok && !ld_issue && !st_issue && (ld_pop || st_pop)) |=> (ld_ok && st_ok));

endmodule

// File: tb/sim_lsq_credit_gate.sv
`timescale 1ns/1ps
module sim_lsq_credit_gate;
  localparam int LW = 4, SW = 6;
  logic clk = 0, rst = 1;
  logic [LW-1:0] cfg_ld_limit = 8;
  logic [SW-1:0] cfg_st_limit = 32;
  logic cfg_shared = 0;
  logic ld_issue = 0, st_issue = 0, ld_pop = 0, st_pop = 0;
  logic ld_ok, st_ok, ld_ovf_err, st_ovf_err;

  always #2.5 clk = ~clk;

  lsq_credit_gate u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  int mld, mst, mll, msl;
  bit msh, mbusy, mle, mse;

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ld_ok", ld_ok, msh ? !mbusy : (mld > 0));
    chk(tag, "st_ok", st_ok, msh ? !mbusy : (mst > 0));
    chk(tag, "ld_ovf_err", ld_ovf_err, mle);
    chk(tag, "st_ovf_err", st_ovf_err, mse);
  endtask

  task automatic do_reset(int ll, int sl, bit sh);
    @(negedge clk);
    cfg_ld_limit = LW'(ll); cfg_st_limit = SW'(sl); cfg_shared = sh;
    ld_issue = 0; st_issue = 0; ld_pop = 0; st_pop = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    mll = (ll > 8) ? 8 : ll; msl = (sl > 32) ? 32 : sl;
    mld = mll; mst = msl; msh = sh; mbusy = 0; mle = 0; mse = 0;
  endtask

  task automatic step(string tag, bit li, bit si, bit lp, bit sp);
    bit lgo, sgo, lov, sov;
    @(negedge clk);
    compare(tag);
    ld_issue = li; st_issue = si; ld_pop = lp; st_pop = sp;
    if (msh) begin
      lgo = li && !mbusy;
      sgo = si && !mbusy && !lgo;
      lov = lp && !mbusy;
      sov = sp && (!mbusy || lp);
      if (lgo || sgo) mbusy = 1;
      else if (lp || sp) mbusy = 0;
    end else begin
      lgo = li && mld > 0;
      sgo = si && mst > 0;
      lov = lp && !lgo && mld == mll;
      sov = sp && !sgo && mst == msl;
      if (lgo && !lp) mld--;
      else if (lp && !lgo && !lov) mld++;
      if (sgo && !sp) mst--;
      else if (sp && !sgo && !sov) mst++;
    end
    if (lov) mle = 1;
    if (sov) mse = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state and config ignored outside reset
    do_reset(8, 32, 0);
    step("R1", 0, 0, 0, 0);
    cfg_ld_limit = 1; cfg_st_limit = 1; cfg_shared = 1;
    step("R1", 0, 0, 0, 0);
    // R2: drain loads
    repeat (8) step("R2", 1, 0, 0, 0);
    // R3: issues ignored at zero
    repeat (2) step("R3", 1, 0, 0, 0);
    // R4: pop restores, issue+pop holds
    step("R4", 1, 0, 1, 0);
    step("R4", 1, 0, 1, 0);
    repeat (7) step("R4", 0, 0, 1, 0);
    // R5: overflow and sticky
    step("R5", 0, 0, 1, 0);
    step("R5", 1, 0, 0, 0);
    step("R5", 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0);
    // R6: store pool, with concurrent loads
    for (int i = 0; i < 32; i++) step("R6", i < 3, 1, i < 3, 0);
    step("R6", 0, 1, 0, 0);
    step("R6", 0, 1, 1, 1);
    for (int i = 0; i < 31; i++) step("R6", 0, 0, 0, 1);
    step("R6", 0, 1, 0, 1);
    step("R6", 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0);
    // R9: clamp
    do_reset(12, 40, 0);
    step("R1", 0, 0, 0, 0);
    repeat (9) step("R9", 1, 1, 0, 0);
    step("R9", 0, 0, 0, 0);
    // R1: zero limit
    do_reset(0, 2, 0);
    step("R1", 1, 1, 0, 0);
    step("R1", 1, 0, 0, 0);
    // R7/R8: shared mode
    do_reset(8, 32, 1);
    step("R7", 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0);
    step("R7", 1, 1, 0, 0);
    step("R8", 0, 0, 0, 1);
    step("R8", 0, 0, 1, 0);
    step("R7", 0, 1, 0, 0);
    step("R8", 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0);
    do_reset(8, 32, 1);
    step("R8", 0, 0, 0, 1);
    step("R8", 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0);
    finish_run();
  end
endmodule